// File: doc/BRIEF.md
# Integer Butterfly Multiply-Accumulate Unit

This block performs one step of an integer FFT or DCT butterfly. Each transaction carries an accumulator operand A, a partner operand B, a coefficient C, the previous value of a second accumulator S, and a 4-bit rotate amount. The unit forms A+B and A−B. It multiplies both by the same coefficient and keeps the low word of each product. It rotates each product right by the rotate amount and adds the two rotated products into the two accumulators. Both new accumulator values leave the unit together.

The datapath has three register stages: add/subtract, multiply, and rotate-plus-accumulate. Operands enter through a valid/ready handshake and results leave through another. When the output is stalled, each stage holds its contents. Empty stages still fill, so gaps between transactions close up. All arithmetic wraps modulo 2^64.

Top module: `bfly_mac_unit`

## Requirements
- R1: The unit computes sum = A + B and diff = A − B modulo 2^64. Both use the A value that came with the same transaction.
- R2: Both sum and diff are multiplied by the one coefficient C, and only the low 64 bits of each product are kept.
- R3: Each product is rotated right by SH positions, with SH from 0 to 15. Bits that leave the low end re-enter at bit 63, so nothing is sign-filled or lost.
- R4: With SH = 0 the product passes through the rotator unchanged.
- R5: out_a = A + rotr(sum·C, SH) and out_s = S + rotr(diff·C, SH), both modulo 2^64, delivered in the same output beat.
- R6: Every input accepted on a rising edge with in_valid and in_ready both high yields exactly one output beat. Output beats come out in input order, and no transaction is dropped or duplicated.
- R7: With out_ready held high, a transaction accepted on clock edge k shows out_valid high and its results from edge k+2 onward.
- R8: While out_valid is high and out_ready is low, out_valid, out_a and out_s stay unchanged. Once all three stages are occupied, in_ready is low.
- R9: While rst_n is low and right after it is released, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Unit can accept an operand beat |
| in_a | input | 64 | Accumulator operand A |
| in_b | input | 64 | Partner operand B |
| in_c | input | 64 | Shared coefficient C |
| in_s | input | 64 | Previous value of second accumulator S |
| in_sh | input | 4 | Right-rotate amount 0..15 |
| out_valid | output | 1 | Result beat available |
| out_ready | input | 1 | Consumer takes the result beat |
| out_a | output | 64 | New value of accumulator A |
| out_s | output | 64 | New value of accumulator S |

## Verification
A result is due two rising edges after the edge that accepts its operands, because it passes through three register stages. The bench drives inputs on falling edges. It samples both handshakes at the falling edge just before the rising edge that uses them, and reads the outcome at the next falling edge. The latency test counts falling edges after a single accepted beat and expects out_valid low at the first two and high at the third. Under random backpressure, an in-order queue of expected pairs keeps each comparison tied to its own transaction, however many stall cycles come between.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int DATA_W  = 64;
  localparam int SH_W    = 4;
  localparam int LANES   = 2;   // lane 0: sum path into A, lane 1: difference path into S
  localparam int NSTAGE  = 3;

  typedef logic [DATA_W-1:0]            word_t;
  typedef logic [LANES-1:0][DATA_W-1:0] lanes_t;

  typedef struct packed {
    lanes_t            ab;    // sum, difference
    lanes_t            acc;   // A, S
    word_t             coef;
    logic [SH_W-1:0]   sh;
  } st0_t;

  typedef struct packed {
    lanes_t            prod;
    lanes_t            acc;
    logic [SH_W-1:0]   sh;
  } st1_t;
endpackage

// File: rtl/bfly_ctl.sv
module bfly_ctl #(
  parameter int NST = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           out_ready,
  output logic           in_ready,
  output logic [NST-1:0] vld,
  output logic [NST-1:0] ld
);
  logic [NST:0]   rdy;
  logic [NST-1:0] src;
  logic [NST-1:0] vld_d;
  logic [NST-1:0] vld_q;

  assign rdy[NST] = out_ready;

  for (genvar k = 0; k < NST; k++) begin : g_stage
    assign rdy[k] = !vld_q[k] || rdy[k+1];
    assign ld[k]  = rdy[k];
    if (k == 0) begin : g_first
      assign src[k] = in_valid;
    end else begin : g_rest
      assign src[k] = vld_q[k-1];
    end
  end

  always_comb begin
    for (int k = 0; k < NST; k++) begin
      vld_d[k] = ld[k] ? src[k] : vld_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign vld      = vld_q;
  assign in_ready = rdy[0];

  // Checker support: marks that one full cycle has passed since reset
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  logic in_fire, out_fire;
  assign in_fire  = in_valid && in_ready;
  assign out_fire = vld_q[NST-1] && out_ready;

  assert_no_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> ($countones(vld_q) ==
                $countones($past(vld_q)) + int'($past(in_fire)) - int'($past(out_fire))));

  assert_full_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&vld_q && !out_ready) |-> !in_ready);

  assert_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> vld_q[0]);
endmodule

// File: rtl/bfly_addsub.sv
module bfly_addsub #(
  parameter int W = 64
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  output logic [1:0][W-1:0] ab
);
  always_comb begin
    ab[0] = a + b;
    ab[1] = a - b;
  end

  always_comb begin
    assert_sumdiff_R1: assert (ab[0] + ab[1] == (a << 1));
  end
endmodule

// File: rtl/bfly_mulpair.sv
module bfly_mulpair #(
  parameter int W     = 64,
  parameter int LANES = 2
) (
  input  logic [LANES-1:0][W-1:0] x,
  input  logic [W-1:0]            coef,
  output logic [LANES-1:0][W-1:0] prod
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [2*W-1:0] full;
    assign full    = {{W{1'b0}}, x[l]} * {{W{1'b0}}, coef};
    assign prod[l] = full[W-1:0];
  end
endmodule

// File: rtl/bfly_rotacc.sv
module bfly_rotacc #(
  parameter int W   = 64,
  parameter int SHW = 4
) (
  input  logic [W-1:0]   prod,
  input  logic [W-1:0]   acc,
  input  logic [SHW-1:0] sh,
  output logic [W-1:0]   res
);
  localparam int CNTW = $clog2(W) + 1;
  logic [W-1:0]   rot;
  logic [CNTW:0]  back;

  always_comb begin
    back = CNTW'(W) - CNTW'(sh);
    rot  = (prod >> sh) | (prod << back);
    res  = acc + rot;
  end

  always_comb begin
    assert_rot_bits_R3: assert ($countones(rot) == $countones(prod));
    if (sh == '0) begin
      assert_rot_zero_R4: assert (rot == prod);
    end
  end
endmodule

// File: rtl/bfly_mac_unit.sv
module bfly_mac_unit
  import bfly_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [63:0]     in_a,
  input  logic [63:0]     in_b,
  input  logic [63:0]     in_c,
  input  logic [63:0]     in_s,
  input  logic [3:0]      in_sh,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [63:0]     out_a,
  output logic [63:0]     out_s
);
  logic [NSTAGE-1:0] vld, ld;

  bfly_ctl #(.NST(NSTAGE)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .vld       (vld),
    .ld        (ld)
  );

  // Stage 0: add / subtract
  st0_t   s0_d, s0_q;
  lanes_t ab_w;

  bfly_addsub #(.W(DATA_W)) u_addsub (
    .a  (in_a),
    .b  (in_b),
    .ab (ab_w)
  );

  always_comb begin
    s0_d.ab     = ab_w;
    s0_d.acc[0] = in_a;
    s0_d.acc[1] = in_s;
    s0_d.coef   = in_c;
    s0_d.sh     = in_sh;
  end

  always_ff @(posedge clk) begin
    if (ld[0]) s0_q <= s0_d;
  end

  // Stage 1: shared-coefficient multiply
  st1_t   s1_d, s1_q;
  lanes_t prod_w;

  bfly_mulpair #(.W(DATA_W), .LANES(LANES)) u_mul (
    .x    (s0_q.ab),
    .coef (s0_q.coef),
    .prod (prod_w)
  );

  always_comb begin
    s1_d.prod = prod_w;
    s1_d.acc  = s0_q.acc;
    s1_d.sh   = s0_q.sh;
  end

  always_ff @(posedge clk) begin
    if (ld[1]) s1_q <= s1_d;
  end

  // Stage 2: rotate and accumulate
  lanes_t res_d, res_q;

  for (genvar l = 0; l < LANES; l++) begin : g_acc
    bfly_rotacc #(.W(DATA_W), .SHW(SH_W)) u_rotacc (
      .prod (s1_q.prod[l]),
      .acc  (s1_q.acc[l]),
      .sh   (s1_q.sh),
      .res  (res_d[l])
    );
  end

  always_ff @(posedge clk) begin
    if (ld[2]) res_q <= res_d;
  end

  assign out_valid = vld[NSTAGE-1];
  assign out_a     = res_q[0];
  assign out_s     = res_q[1];

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_a) && $stable(out_s)));

  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready));
endmodule

// File: tb/bfly_mac_unit_test.sv
`timescale 1ns/1ps
module bfly_mac_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [63:0] in_a, in_b, in_c, in_s, out_a, out_s;
  logic [3:0]  in_sh;

  always #10 clk = ~clk;

  bfly_mac_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_s(in_s), .in_sh(in_sh),
    .out_valid(out_valid), .out_ready(out_ready), .out_a(out_a), .out_s(out_s)
  );

  typedef struct { logic [63:0] ea; logic [63:0] es; string tag; } exp_t;
  exp_t q[$];

  int nchk = 0, nerr = 0;
  bit done = 0, rnd_ready = 0, last_fi = 0, use_hand = 0;
  logic [63:0] hand_a, hand_s;
  string cur_tag = "R5";

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_rotr(logic [63:0] x, int sh);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = x[(i + sh) % 64];
    return r;
  endfunction

  function automatic exp_t ref_model(logic [63:0] a, b, c, s, int sh);
    exp_t e;
    logic [63:0] sm, df;
    sm = a + b;
    df = a - b;
    e.ea = a + ref_rotr(sm * c, sh);
    e.es = s + ref_rotr(df * c, sh);
    return e;
  endfunction

  // One clock: sample handshakes before the rising edge, evaluate after it.
  task automatic cycle();
    bit fi, fo, stall;
    logic [63:0] oa, os;
    exp_t e;
    if (rnd_ready) out_ready = ($urandom_range(3) != 0);
    #1;
    fi = in_valid && in_ready;
    fo = out_valid && out_ready;
    stall = out_valid && !out_ready;
    oa = out_a; os = out_s;
    if (fi) begin
      e = ref_model(in_a, in_b, in_c, in_s, int'(in_sh));
      if (use_hand) begin e.ea = hand_a; e.es = hand_s; end
      e.tag = cur_tag;
    end
    @(posedge clk); @(negedge clk);
    if (fo) begin
      if (q.size() == 0) chk(0, "R6 unexpected beat", oa, 64'h0);
      else begin
        exp_t x;
        x = q.pop_front();
        chk(oa == x.ea, {x.tag, " out_a"}, oa, x.ea);
        chk(os == x.es, {x.tag, " out_s"}, os, x.es);
      end
    end
    if (fi) q.push_back(e);
    if (stall) begin
      chk(out_valid == 1'b1, "R8 valid held", {63'h0, out_valid}, 64'h1);
      chk(out_a == oa && out_s == os, "R8 data held", out_a, oa);
    end
    last_fi = fi;
  endtask

  task automatic send(logic [63:0] a, b, c, s, logic [3:0] sh);
    in_valid = 1'b1; in_a = a; in_b = b; in_c = c; in_s = s; in_sh = sh;
    do cycle(); while (!last_fi);
    in_valid = 1'b0;
  endtask

  task automatic send_hand(logic [63:0] a, b, c, s, logic [3:0] sh,
                           logic [63:0] ea, es, string tag);
    use_hand = 1; hand_a = ea; hand_s = es; cur_tag = tag;
    send(a, b, c, s, sh);
    use_hand = 0; cur_tag = "R5";
  endtask

  task automatic drain();
    rnd_ready = 0; out_ready = 1'b1; in_valid = 1'b0;
    for (int i = 0; i < 20 && q.size() != 0; i++) cycle();
    chk(q.size() == 0, "R6 all results delivered", 64'(q.size()), 64'h0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL R6 watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [63:0] corner [3];
    corner[0] = 64'h0; corner[1] = '1; corner[2] = 64'h8000_0000_0000_0000;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_a = '0; in_b = '0; in_c = '0; in_s = '0; in_sh = '0;
    repeat (3) @(negedge clk);
    // R9: idle state during reset
    chk(out_valid == 1'b0, "R9 out_valid in reset", {63'h0, out_valid}, 64'h0);
    chk(in_ready == 1'b1, "R9 in_ready in reset", {63'h0, in_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 out_valid after reset", {63'h0, out_valid}, 64'h0);
    chk(in_ready == 1'b1, "R9 in_ready after reset", {63'h0, in_ready}, 64'h1);

    // R7: latency with out_ready high
    out_ready = 1'b1;
    send_hand(64'd3, 64'd1, 64'd2, 64'd10, 4'd1, 64'd7, 64'd12, "R5 small");
    chk(out_valid == 1'b0, "R7 not yet after accept edge", {63'h0, out_valid}, 64'h0);
    cycle();
    chk(out_valid == 1'b0, "R7 not yet after edge k+1", {63'h0, out_valid}, 64'h0);
    cycle();
    chk(out_valid == 1'b1, "R7 valid after edge k+2", {63'h0, out_valid}, 64'h1);
    drain();

    // Directed arithmetic cases
    send_hand(64'd5, 64'd3, 64'd1, 64'd0, 4'd0, 64'd13, 64'd2, "R1 sum/diff");
    send_hand(64'd5, 64'd3, 64'd3, 64'd0, 4'd0, 64'd29, 64'd6, "R2 shared coef");
    send_hand(64'd1, 64'd0, 64'd1, 64'd0, 4'd1,
              64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000, "R3 wrap-around");
    send_hand(64'd0, 64'd0, 64'd0, 64'h1234, 4'd15, 64'd0, 64'h1234, "R5 zero product");
    send_hand(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd7, 64'd1, 4'd0,
              64'h8000_0000_0000_0000, 64'd1, "R1 wrap min-neg");
    drain();

    // R8: backpressure fills three stages, then blocks input
    out_ready = 1'b0;
    send(64'd11, 64'd2, 64'd3, 64'd4, 4'd2);
    send(64'd12, 64'd2, 64'd3, 64'd4, 4'd3);
    send(64'd13, 64'd2, 64'd3, 64'd4, 4'd4);
    in_valid = 1'b1; in_a = 64'd14; in_b = 64'd2; in_c = 64'd3; in_s = 64'd4; in_sh = 4'd5;
    #1;
    chk(in_ready == 1'b0, "R8 in_ready low when full", {63'h0, in_ready}, 64'h0);
    cycle(); cycle(); cycle();
    out_ready = 1'b1;
    do cycle(); while (!last_fi);
    in_valid = 1'b0;
    drain();

    // R4 / R3: every rotate amount against corner operands
    out_ready = 1'b1;
    for (int sh = 0; sh < 16; sh++) begin
      cur_tag = (sh == 0) ? "R4 corner" : "R3 corner";
      for (int ia = 0; ia < 3; ia++)
        for (int ib = 0; ib < 3; ib++)
          for (int ic = 0; ic < 3; ic++)
            send(corner[ia], corner[ib], corner[ic], corner[(ia + ic) % 3], 4'(sh));
    end
    cur_tag = "R5";
    drain();

    // R6 / R5: random stimulus with random gaps and backpressure
    void'($urandom(32'd7331));
    rnd_ready = 1;
    cur_tag = "R6 random";
    for (int n = 0; n < 600; n++) begin
      logic [63:0] ra, rb, rc, rs;
      ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
      rc = (n % 4 == 0) ? 64'($urandom_range(65535)) : {$urandom, $urandom};
      rs = {$urandom, $urandom};
      send(ra, rb, rc, rs, 4'($urandom_range(15)));
      if ($urandom_range(3) == 0) cycle();
    end
    cur_tag = "R5";
    drain();

    done = 1;
    finish_run();
  end
endmodule